// File: doc/BRIEF.md
# Floppy Controller Digital Output Register

This block is the drive-control register of a floppy disk controller. The host reads and writes it as one byte at a fixed offset from the controller's base address. The byte holds four motor enables, one enable for the DMA and interrupt pins, a bit that holds the controller core in reset, and a two-bit drive number. The block turns these fields into active-low motor and drive-select outputs and a soft-reset level for the controller core. It also provides the gating for the DMA request, DMA acknowledge, terminal count and interrupt pins.

The gating depends on an interface-mode input. In AT mode the DMA/interrupt enable bit decides whether the acknowledge and terminal-count inputs reach the core, and whether the request and interrupt pads are driven. In PS/2 mode these pins are always live. The block does not contain the pad tri-state buffers. It supplies an output-enable signal and gated data for them.

The core reset is a level. It rises when software clears the reset bit and stays high until software sets the bit again. After that it is held for a fixed number of extra cycles, so two back-to-back writes still give a reset pulse of usable length. Only the hardware reset clears the stored byte. The soft reset never alters it.

Top module: `fdc_dor`

## Requirements
- R1: A write with `host_addr` equal to REG_OFFSET (default 2) stores all 8 bits of `host_wdata` at the next clock edge. While `host_addr` equals REG_OFFSET, `host_rdata` shows the stored byte. At any other address writes are ignored and `host_rdata` reads 0.
- R2: While `rst_n` is low at a clock edge, the stored byte becomes 0x00. `soft_rst` is high whenever `rst_n` is low.
- R3: Bits 1:0 hold the drive number. Value 0 drives `drv_sel_n[0]` low, value 1 drives `drv_sel_n[1]` low, and values 2 and 3 leave both high. At most one `drv_sel_n` line is ever low.
- R4: Bits 7:4 are motor enables 3:0. `mtr_n[k]` is low exactly when motor enable k is 1.
- R5: While bit 2 (core run) of the stored byte is 0, `soft_rst` is high.
- R6: Once bit 2 returns to 1, `soft_rst` stays high for exactly SRST_HOLD_CYC further clock cycles (default 10) and then falls. A 0-write followed at once by a 1-write therefore gives a pulse of SRST_HOLD_CYC+1 cycles.
- R7: While `soft_rst` is high, the stored byte changes only through host writes.
- R8: In AT mode (`ps2_mode`=0) with bit 3 (DMA/interrupt enable) set to 1, `pad_oe` is 1. `dack_n_core` follows `dack_n_pad`, `tc_core` follows `tc_pad`, `drq_pad` follows `drq_core`, and `irq_pad` follows `irq_core`.
- R9: In AT mode with bit 3 at 0, `pad_oe` is 0, `dack_n_core` is 1, and `tc_core`, `drq_pad` and `irq_pad` are 0.
- R10: In PS/2 mode (`ps2_mode`=1), all four pins pass through as in R8 whatever the value of bit 3, during hardware and soft reset as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| host_addr | input | ADDR_W | Host register address within the controller |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Readback, 0 when not addressed |
| ps2_mode | input | 1 | 1 = PS/2 interface mode, 0 = AT mode |
| dack_n_pad | input | 1 | DMA acknowledge from the pin, active low |
| tc_pad | input | 1 | Terminal count from the pin |
| drq_core | input | 1 | DMA request from the controller core |
| irq_core | input | 1 | Interrupt from the controller core |
| dack_n_core | output | 1 | Gated DMA acknowledge to the core |
| tc_core | output | 1 | Gated terminal count to the core |
| drq_pad | output | 1 | DMA request data for the pad |
| irq_pad | output | 1 | Interrupt data for the pad |
| pad_oe | output | 1 | Output enable for the request and interrupt pads |
| drv_sel_n | output | NUM_DS | Active-low drive selects |
| mtr_n | output | 4 | Active-low motor enables |
| soft_rst | output | 1 | Reset level for the controller core |

## Verification
Two functions can act in the same cycle: a host write to the register, and a reset that would clear or hold state. The bench issues a write in the same cycle that `rst_n` is low, and the cleared byte must win. It also writes the run bit back to 0 while the post-release hold count is still running, and the hold must re-arm to its full length. A cycle-level model in the bench tracks the byte and the remaining hold count and judges every output on every cycle. That model is what shows the overlap was resolved correctly.

// File: rtl/fdc_dor_pkg.sv
// Package: shared layout of the drive-control byte.
// Assumes the byte layout is fixed by the host-visible bit positions.
package fdc_dor_pkg;

    localparam int DOR_W   = 8;
    localparam int MOTOR_N = 4;

    // Field layout, most significant field first.
    typedef struct packed {
        logic [MOTOR_N-1:0] motor_en;  // bits 7:4
        logic               dma_en;    // bit 3
        logic               run_n;     // bit 2, 0 holds the core in reset
        logic [1:0]         drive_no;  // bits 1:0
    } dor_t;

endpackage

// File: rtl/fdc_dor_regs.sv
// Module: byte storage with address decode and readback.
// Assumes one-cycle write strobes. Only rst_n clears the byte.
module fdc_dor_regs
    import fdc_dor_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int REG_OFFSET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [DOR_W-1:0]  host_wdata,
    output logic [DOR_W-1:0]  host_rdata,
    output dor_t              dor_q
);

    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    logic hit;

    // Address match for this register.
    always_comb hit = (host_addr == OFFS);

    // Storage: hardware reset clears, a matching write loads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dor_q <= '0;
        else if (host_wr && hit)
            dor_q <= dor_t'(host_wdata);
    end

    // Readback multiplexer, zero when not addressed.
    always_comb host_rdata = hit ? DOR_W'(dor_q) : '0;

endmodule

// File: rtl/fdc_dor_srst.sv
// Module: soft-reset level with minimum hold after release.
// Assumes HOLD_CYC is counted in clk cycles after run_n returns to 1.
module fdc_dor_srst #(
    parameter int HOLD_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_n,
    output logic soft_rst
);

    generate
        if (HOLD_CYC > 0) begin : g_hold
            localparam int CW = $clog2(HOLD_CYC + 1);
            localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);
            logic [CW-1:0] left_q;

            // Countdown: re-armed while run_n is 0, drains once it is 1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    left_q <= '0;
                else if (!run_n)
                    left_q <= HOLD_V;
                else if (left_q != '0)
                    left_q <= left_q - 1'b1;
            end

            // Reset level to the core.
            always_comb soft_rst = !rst_n || !run_n || (left_q != '0);
        end else begin : g_nohold
            // Reset level to the core without a hold window.
            always_comb soft_rst = !rst_n || !run_n;
        end
    endgenerate

endmodule

// File: rtl/fdc_dor_drv_out.sv
// Module: active-low drive-select decode and motor outputs.
// Assumes NUM_DS is 1 to 4. Drive numbers with no pin select nothing.
module fdc_dor_drv_out
    import fdc_dor_pkg::*;
#(
    parameter int NUM_DS = 2
) (
    input  logic [1:0]         drive_no,
    input  logic [MOTOR_N-1:0] motor_en,
    output logic [NUM_DS-1:0]  drv_sel_n,
    output logic [MOTOR_N-1:0] mtr_n
);

    genvar i;
    generate
        for (i = 0; i < NUM_DS; i++) begin : g_ds
            // One select line per decoded drive number.
            always_comb drv_sel_n[i] = !(drive_no == 2'(i));
        end
        for (i = 0; i < MOTOR_N; i++) begin : g_mtr
            // Motor line asserted low from its enable bit.
            always_comb mtr_n[i] = !motor_en[i];
        end
    endgenerate

endmodule

// File: rtl/fdc_dor_dma_gate.sv
// Module: mode-dependent gating of DMA and interrupt pins.
// Assumes the pad tri-state buffers are outside and use pad_oe.
module fdc_dor_dma_gate (
    input  logic ps2_mode,
    input  logic dma_en,
    input  logic dack_n_pad,
    input  logic tc_pad,
    input  logic drq_core,
    input  logic irq_core,
    output logic dack_n_core,
    output logic tc_core,
    output logic drq_pad,
    output logic irq_pad,
    output logic pad_oe
);

    logic live;

    // Pins are live in PS/2 mode, or in AT mode when enabled.
    always_comb live = ps2_mode || dma_en;

    // Inbound gating: idle levels when disabled.
    always_comb begin
        dack_n_core = live ? dack_n_pad : 1'b1;
        tc_core     = live ? tc_pad     : 1'b0;
    end

    // Outbound gating: enable plus quiet data when disabled.
    always_comb begin
        pad_oe  = live;
        drq_pad = live && drq_core;
        irq_pad = live && irq_core;
    end

endmodule

// File: rtl/fdc_dor.sv
// Module: top of the drive-control register.
// Assumes a single clock domain with synchronous active-low reset.
module fdc_dor
    import fdc_dor_pkg::*;
#(
    parameter int ADDR_W        = 3,
    parameter int REG_OFFSET    = 2,
    parameter int NUM_DS        = 2,
    parameter int SRST_HOLD_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              ps2_mode,
    input  logic              dack_n_pad,
    input  logic              tc_pad,
    input  logic              drq_core,
    input  logic              irq_core,
    output logic              dack_n_core,
    output logic              tc_core,
    output logic              drq_pad,
    output logic              irq_pad,
    output logic              pad_oe,
    output logic [NUM_DS-1:0] drv_sel_n,
    output logic [3:0]        mtr_n,
    output logic              soft_rst
);

    dor_t dor_q;

    fdc_dor_regs #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dor_q(dor_q)
    );

    fdc_dor_srst #(.HOLD_CYC(SRST_HOLD_CYC)) u_srst (
        .clk(clk), .rst_n(rst_n), .run_n(dor_q.run_n), .soft_rst(soft_rst)
    );

    fdc_dor_drv_out #(.NUM_DS(NUM_DS)) u_drv (
        .drive_no(dor_q.drive_no), .motor_en(dor_q.motor_en),
        .drv_sel_n(drv_sel_n), .mtr_n(mtr_n)
    );

    fdc_dor_dma_gate u_gate (
        .ps2_mode(ps2_mode), .dma_en(dor_q.dma_en),
        .dack_n_pad(dack_n_pad), .tc_pad(tc_pad),
        .drq_core(drq_core), .irq_core(irq_core),
        .dack_n_core(dack_n_core), .tc_core(tc_core),
        .drq_pad(drq_pad), .irq_pad(irq_pad), .pad_oe(pad_oe)
    );

endmodule

// File: rtl/fdc_dor_chk.sv
// Module: property checker bound to fdc_dor, port-level only.
module fdc_dor_chk #(
    parameter int ADDR_W     = 3,
    parameter int REG_OFFSET = 2,
    parameter int NUM_DS     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              ps2_mode,
    input logic              dack_n_core,
    input logic              tc_core,
    input logic              pad_oe,
    input logic [NUM_DS-1:0] drv_sel_n,
    input logic [3:0]        mtr_n,
    input logic              soft_rst
);

    localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

    // R1: a write is visible on readback one cycle later
    assert_write_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFFS) |=> (host_addr != OFFS || host_rdata == $past(host_wdata)));

    // R2: hardware reset clears the byte
    assert_hw_clear_R2: assert property (@(posedge clk)
        (!rst_n) |=> (host_rdata == 8'h00));

    // R3: never more than one drive selected
    assert_one_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~drv_sel_n));

    // R4: motor lines follow readback fields
    assert_motor_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == OFFS) |-> (mtr_n == ~host_rdata[7:4]));

    // R5: run bit at 0 means core in reset
    assert_run_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == OFFS && !host_rdata[2]) |-> soft_rst);

    // R7: without a write the byte holds, soft reset or not
    assert_no_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && host_addr == OFFS) |=> (host_addr != OFFS || $stable(host_rdata)));

    // R9: disabled pins idle in AT mode
    assert_idle_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pad_oe) |-> (dack_n_core && !tc_core));

    // R10: PS/2 mode always enables
    assert_ps2_live_R10: assert property (@(posedge clk)
        ps2_mode |-> pad_oe);

endmodule

bind fdc_dor fdc_dor_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .NUM_DS(NUM_DS)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ps2_mode(ps2_mode),
    .dack_n_core(dack_n_core), .tc_core(tc_core), .pad_oe(pad_oe),
    .drv_sel_n(drv_sel_n), .mtr_n(mtr_n), .soft_rst(soft_rst)
);

// File: tb/test_fdc_dor.sv
// Bench: directed stimulus plus a behavioural per-cycle model.
module test_fdc_dor;

    localparam int AW   = 3;
    localparam int OFF  = 2;
    localparam int NDS  = 2;
    localparam int HOLD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] host_addr = AW'(OFF);
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic ps2_mode = 1'b0, dack_n_pad = 1'b1, tc_pad = 1'b0, drq_core = 1'b0, irq_core = 1'b0;
    logic dack_n_core, tc_core, drq_pad, irq_pad, pad_oe, soft_rst;
    logic [NDS-1:0] drv_sel_n;
    logic [3:0] mtr_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    int m_byte = 0;
    int m_left = 0;

    always #5 clk = ~clk;

    fdc_dor #(.ADDR_W(AW), .REG_OFFSET(OFF), .NUM_DS(NDS), .SRST_HOLD_CYC(HOLD)) i_fdc_dor (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ps2_mode(ps2_mode),
        .dack_n_pad(dack_n_pad), .tc_pad(tc_pad), .drq_core(drq_core), .irq_core(irq_core),
        .dack_n_core(dack_n_core), .tc_core(tc_core), .drq_pad(drq_pad), .irq_pad(irq_pad),
        .pad_oe(pad_oe), .drv_sel_n(drv_sel_n), .mtr_n(mtr_n), .soft_rst(soft_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at the edge, from inputs stable since the previous edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_byte = 0;
            m_left = 0;
        end else begin
            if (((m_byte >> 2) & 1) == 0) m_left = HOLD;
            else if (m_left > 0) m_left = m_left - 1;
            if (host_wr && host_addr == AW'(OFF)) m_byte = host_wdata;
        end
    end

    // Compare every output at the falling edge.
    always @(negedge clk) begin
        if (!done) begin
            automatic int live = ps2_mode || ((m_byte >> 3) & 1);
            automatic int dno = m_byte & 3;
            check("R1", host_rdata, (host_addr == AW'(OFF)) ? m_byte : 0);
            check("R3", drv_sel_n, (dno == 0) ? 2'b10 : (dno == 1) ? 2'b01 : 2'b11);
            check("R4", mtr_n, (~(m_byte >> 4)) & 4'hF);
            check("R5_R6", soft_rst, (!rst_n || ((m_byte >> 2) & 1) == 0 || m_left > 0) ? 1 : 0);
            check("R8_R9_R10", pad_oe, live);
            check("R8_R9_R10", dack_n_core, live ? dack_n_pad : 1);
            check("R8_R9_R10", tc_core, live ? tc_pad : 0);
            check("R8_R9_R10", drq_pad, live ? drq_core : 0);
            check("R8_R9_R10", irq_pad, live ? irq_core : 0);
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        host_addr = AW'(a); host_wdata = 8'(d); host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; host_addr = AW'(OFF);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Watchdog
    initial begin
        #500000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2: reset state, write during reset is ignored
        idle(2);
        host_wdata = 8'hFF; host_wr = 1'b1;
        idle(1);
        host_wr = 1'b0;
        idle(1);
        #4; check("R2", host_rdata, 0); check("R2", soft_rst, 1);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(3);
        #4; check("R2", soft_rst, 1);

        // R1: other address ignored
        wr(5, 8'hF7);
        #4; check("R1", host_rdata, 0);
        @(posedge clk); #1;

        // R3/R4: drive numbers and motors
        for (int d = 0; d < 4; d++) begin
            wr(OFF, (8'h10 << d) | 8'h04 | d);
            idle(1);
        end
        // R6: release then measure hold length
        wr(OFF, 8'h00);
        wr(OFF, 8'h04);
        idle(HOLD - 2);
        #4; check("R6", soft_rst, 1);
        idle(2);
        #4; check("R6", soft_rst, 0);

        // R6 overlap: rewrite 0 inside hold window re-arms full hold
        wr(OFF, 8'h00);
        wr(OFF, 8'h04);
        idle(3);
        wr(OFF, 8'h00);
        wr(OFF, 8'h04);
        idle(HOLD + 2);

        // R7: soft reset held, contents stay
        wr(OFF, 8'hA9);
        idle(5);
        #4; check("R7", host_rdata, 8'hA9); check("R5", soft_rst, 1);
        @(posedge clk); #1;

        // R8/R9/R10: pin gating across modes
        for (int p = 0; p < 16; p++) begin
            wr(OFF, (p & 1) ? 8'h0C : 8'h04);
            ps2_mode = p[1]; dack_n_pad = p[2]; tc_pad = p[3];
            drq_core = ~p[2]; irq_core = p[3] ^ p[0];
            idle(2);
        end
        ps2_mode = 1'b1;
        // R10: hardware reset overlaps a write in PS/2 mode
        @(posedge clk); #1; rst_n = 1'b0; host_wr = 1'b1; host_wdata = 8'h3B;
        idle(1); host_wr = 1'b0;
        idle(1);
        #4; check("R10", pad_oe, 1); check("R2", host_rdata, 0);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(4);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule